// File: doc/BRIEF.md
# Strip Channel Digitizer with Sparse Readout

This block is the digital back end of a 128-channel strip readout chip. A start pulse opens a conversion window. During the window one shared counter steps from 0 to full scale. Each channel's comparator strobe stores the value the counter holds when the analog ramp crosses that channel's stored level. A channel whose comparator never fires keeps the full-scale code.

When the window closes, a scanner visits the channels from the lowest index to the highest. Each selected channel produces two bytes: its index, then its code. In sparse mode a channel is selected only when its code reaches the chip-wide threshold. In full mode every channel is selected. A trailer byte closes each frame.

Bytes leave on a valid/ready interface. The interface carries at most one byte every two clock cycles, which matches a readout rate of half the digitizing clock.

Top module: `strip_digitizer`

## Requirements
- R1: A start pulse seen while the block is idle opens a conversion window of 256 cycles. A strobe sampled on the k-th rising edge after the edge that accepted start (k = 1..256) stores code k-1 for that channel.
- R2: Within one window, a channel stores only its first strobe. Later strobes to that channel leave its code unchanged.
- R3: A channel that receives no strobe during the window reads 255.
- R4: Strobes have no effect outside the window. This includes strobes on the edge that accepts start and strobes during readout.
- R5: In sparse mode a channel is emitted only when its code is greater than or equal to the threshold. Channels go out in ascending index order. Each emitted channel produces an address byte (bit 7 = 0, bits 6:0 = channel index) followed by a code byte.
- R6: In full mode all 128 channels are emitted, whatever the threshold.
- R7: Each frame ends with the trailer byte 0xF0, which has bit 7 set. A sparse frame with no channel selected is the trailer alone.
- R8: The threshold and the mode are captured on the edge that accepts start. Later changes to them do not affect that frame.
- R9: In the cycle after a byte is accepted, out_valid_o is low. The stream therefore carries at most one byte per two cycles.
- R10: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o stays unchanged. No byte is dropped.
- R11: A start pulse during conversion or readout is ignored. No second frame follows the current one.
- R12: After reset, out_valid_o is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digitizing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a conversion when the block is idle |
| strobe_i | input | 128 | Comparator strobes, one per channel |
| thresh_i | input | 8 | Sparse threshold for the whole chip |
| full_mode_i | input | 1 | 1 = emit every channel, 0 = sparse |
| out_ready_i | input | 1 | Downstream accepts the byte on offer |
| out_data_o | output | 8 | Stream byte: address, code or trailer |
| out_valid_o | output | 1 | A byte is on offer |

## Verification
Five properties are checked on every cycle:
- the idle cycle after each accepted byte;
- that a stalled byte is held;
- that the counter steps by one through the window;
- that stored codes stay frozen outside the window;
- that no byte is offered while the block is idle.

The remaining behaviour can only be shown by the directed frames:
- the exact code each channel stores;
- first-strobe-wins;
- saturation at 255;
- threshold inclusivity;
- ascending order;
- the trailer;
- capture of the settings at start;
- that a stray start produces no second frame.

// File: rtl/strip_pkg.sv
package strip_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_CONV, PH_READ} phase_t;
   typedef enum logic [2:0] {SC_IDLE, SC_PICK, SC_ADDR, SC_GAP, SC_CODE, SC_TLOAD, SC_TRLR} scan_t;
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              frame_done_i,
   output logic [CODE_W-1:0] count_o,
   output logic              conv_begin_o,
   output logic              conv_open_o,
   output logic              conv_last_o,
   output logic              busy_o
);
   import strip_pkg::*;
   localparam logic [CODE_W-1:0] CNT_MAX = {CODE_W{1'b1}};

   phase_t phase;

   assign conv_begin_o = start_i && (phase == PH_IDLE);
   assign conv_open_o  = (phase == PH_CONV);
   assign conv_last_o  = conv_open_o && (count_o == CNT_MAX);
   assign busy_o       = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         count_o <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start_i) begin
               phase   <= PH_CONV;
               count_o <= '0;
            end
            PH_CONV: begin
               count_o <= count_o + 1'b1;
               if (count_o == CNT_MAX) phase <= PH_READ;
            end
            PH_READ: if (frame_done_i) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chan_bank.sv
module chan_bank #(
   parameter int NCH    = 128,
   parameter int CODE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        conv_begin_i,
   input  logic                        conv_open_i,
   input  logic [CODE_W-1:0]           count_i,
   input  logic [NCH-1:0]              strobe_i,
   output logic [NCH-1:0][CODE_W-1:0]  codes_o
);
   localparam logic [CODE_W-1:0] SAT = {CODE_W{1'b1}};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic fired;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fired       <= 1'b0;
            codes_o[ch] <= SAT;
         end else if (conv_begin_i) begin
            fired       <= 1'b0;
            codes_o[ch] <= SAT;
         end else if (conv_open_i && strobe_i[ch] && !fired) begin
            fired       <= 1'b1;
            codes_o[ch] <= count_i;
         end
      end
   end
endmodule

// File: rtl/sparse_scanner.sv
module sparse_scanner #(
   parameter int NCH         = 128,
   parameter int CODE_W      = 8,
   parameter int BYTE_W      = 8,
   parameter int TRAILER_VAL = 'hF0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        begin_i,
   input  logic                        go_i,
   input  logic [CODE_W-1:0]           thr_i,
   input  logic                        full_i,
   input  logic [NCH-1:0][CODE_W-1:0]  codes_i,
   input  logic                        out_ready_i,
   output logic [BYTE_W-1:0]           out_data_o,
   output logic                        out_valid_o,
   output logic                        done_o
);
   import strip_pkg::*;
   localparam int ADDR_W = $clog2(NCH);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NCH - 1);
   localparam logic [BYTE_W-1:0] TRL  = BYTE_W'(TRAILER_VAL);

   scan_t             st;
   logic [ADDR_W-1:0] idx;
   logic [CODE_W-1:0] thr_q;
   logic              full_q;
   logic [CODE_W-1:0] sel_code;
   logic              pass;

   assign sel_code = codes_i[idx];
   assign pass     = full_q || (sel_code >= thr_q);
   assign done_o   = (st == SC_TRLR) && out_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         full_q <= 1'b0;
      end else if (begin_i) begin
         thr_q  <= thr_i;
         full_q <= full_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= SC_IDLE;
         idx         <= '0;
         out_data_o  <= '0;
         out_valid_o <= 1'b0;
      end else begin
         case (st)
            SC_IDLE: if (go_i) begin
               st  <= SC_PICK;
               idx <= '0;
            end
            SC_PICK: begin
               if (pass) begin
                  out_data_o  <= BYTE_W'(idx);
                  out_valid_o <= 1'b1;
                  st          <= SC_ADDR;
               end else if (idx == LAST) begin
                  out_data_o  <= TRL;
                  out_valid_o <= 1'b1;
                  st          <= SC_TRLR;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            SC_ADDR: if (out_ready_i) begin
               out_valid_o <= 1'b0;
               st          <= SC_GAP;
            end
            SC_GAP: begin
               out_data_o  <= BYTE_W'(sel_code);
               out_valid_o <= 1'b1;
               st          <= SC_CODE;
            end
            SC_CODE: if (out_ready_i) begin
               out_valid_o <= 1'b0;
               if (idx == LAST) begin
                  st <= SC_TLOAD;
               end else begin
                  idx <= idx + 1'b1;
                  st  <= SC_PICK;
               end
            end
            SC_TLOAD: begin
               out_data_o  <= TRL;
               out_valid_o <= 1'b1;
               st          <= SC_TRLR;
            end
            SC_TRLR: if (out_ready_i) begin
               out_valid_o <= 1'b0;
               st          <= SC_IDLE;
            end
            default: st <= SC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/strip_digitizer.sv
module strip_digitizer #(
   parameter int NCH         = 128,
   parameter int CODE_W      = 8,
   parameter int BYTE_W      = 8,
   parameter int TRAILER_VAL = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [NCH-1:0]    strobe_i,
   input  logic [CODE_W-1:0] thresh_i,
   input  logic              full_mode_i,
   input  logic              out_ready_i,
   output logic [BYTE_W-1:0] out_data_o,
   output logic              out_valid_o
);
   localparam int ADDR_W = $clog2(NCH);

   if (NCH < 2) begin : g_bad_nch
      $error("strip_digitizer: NCH must be at least 2");
   end
   if (ADDR_W >= BYTE_W) begin : g_bad_addr
      $error("strip_digitizer: channel index must leave a free top bit in a byte");
   end
   if (CODE_W > BYTE_W) begin : g_bad_code
      $error("strip_digitizer: code wider than a byte");
   end
   if ((TRAILER_VAL >> ADDR_W) == 0) begin : g_bad_trl
      $error("strip_digitizer: trailer must not look like an address byte");
   end

   logic                       busy;
   logic                       conv_begin;
   logic                       conv_open;
   logic                       conv_last;
   logic                       frame_done;
   logic [CODE_W-1:0]          count;
   logic [NCH-1:0][CODE_W-1:0] codes;

   conv_timer #(.CODE_W(CODE_W)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .frame_done_i (frame_done),
      .count_o      (count),
      .conv_begin_o (conv_begin),
      .conv_open_o  (conv_open),
      .conv_last_o  (conv_last),
      .busy_o       (busy)
   );

   chan_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_begin_i (conv_begin),
      .conv_open_i  (conv_open),
      .count_i      (count),
      .strobe_i     (strobe_i),
      .codes_o      (codes)
   );

   sparse_scanner #(
      .NCH(NCH), .CODE_W(CODE_W), .BYTE_W(BYTE_W), .TRAILER_VAL(TRAILER_VAL)
   ) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .begin_i     (conv_begin),
      .go_i        (conv_last),
      .thr_i       (thresh_i),
      .full_i      (full_mode_i),
      .codes_i     (codes),
      .out_ready_i (out_ready_i),
      .out_data_o  (out_data_o),
      .out_valid_o (out_valid_o),
      .done_o      (frame_done)
   );
endmodule

// File: rtl/strip_digitizer_chk.sv
module strip_digitizer_chk #(
   parameter int NCH    = 128,
   parameter int CODE_W = 8,
   parameter int BYTE_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       out_valid_o,
   input logic                       out_ready_i,
   input logic [BYTE_W-1:0]          out_data_o,
   input logic                       busy,
   input logic                       conv_begin,
   input logic                       conv_open,
   input logic [CODE_W-1:0]          count,
   input logic [NCH-1:0][CODE_W-1:0] codes
);
   localparam logic [CODE_W-1:0] CNT_MAX = {CODE_W{1'b1}};

   p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && out_ready_i) |=> !out_valid_o);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_open && count != CNT_MAX) |=> (conv_open && count == $past(count) + 1'b1));

   p_codes_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_open && !conv_begin) |=> $stable(codes));

   p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid_o);
endmodule

bind strip_digitizer strip_digitizer_chk #(
   .NCH(NCH), .CODE_W(CODE_W), .BYTE_W(BYTE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .out_valid_o (out_valid_o),
   .out_ready_i (out_ready_i),
   .out_data_o  (out_data_o),
   .busy        (busy),
   .conv_begin  (conv_begin),
   .conv_open   (conv_open),
   .count       (count),
   .codes       (codes)
);

// File: tb/strip_digitizer_bench.sv
module strip_digitizer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 128;
   localparam int TRL = 'hF0;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         start;
   logic [NCH-1:0] strobe;
   logic [7:0]   thr;
   logic         full_mode;
   logic         out_ready;
   logic [7:0]   out_data;
   logic         out_valid;

   int tgt  [NCH];
   int tgt2 [NCH];
   int got[$];
   int exp_q[$];
   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   strip_digitizer u_strip_digitizer (
      .clk(clk), .rst_n(rst_n), .start_i(start), .strobe_i(strobe),
      .thresh_i(thr), .full_mode_i(full_mode), .out_ready_i(out_ready),
      .out_data_o(out_data), .out_valid_o(out_valid)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_targets(input int dflt);
      for (int ch = 0; ch < NCH; ch++) begin
         tgt[ch]  = dflt;
         tgt2[ch] = -1;
      end
   endtask

   function automatic int code_of(input int ch);
      return (tgt[ch] < 0) ? 255 : tgt[ch];
   endfunction

   // rdy_mode: 0 always ready, 1 ready two cycles of three, 2 long stalls
   task automatic run_frame(input int thr_v, input bit full_v, input int rdy_mode,
                            input bit late_cfg, input bit poke_start, input string req);
      int  cyc;
      bit  done;
      bit  v, r, prev_v, prev_r, prev_acc;
      int  d, prev_d;
      int  gap_bad, hold_bad, mism;
      exp_q.delete();
      got.delete();
      for (int ch = 0; ch < NCH; ch++) begin
         if (full_v || code_of(ch) >= thr_v) begin
            exp_q.push_back(ch);
            exp_q.push_back(code_of(ch));
         end
      end
      exp_q.push_back(TRL);
      // start edge: every strobe high, none may take effect (R4)
      @(negedge clk);
      start = 1'b1; thr = 8'(thr_v); full_mode = full_v; strobe = '1;
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         start  = 1'b0;
         strobe = '0;
         for (int ch = 0; ch < NCH; ch++)
            if (tgt[ch] == k || tgt2[ch] == k) strobe[ch] = 1'b1;
         if (late_cfg && k == 0) begin
            thr = 8'd0;
            full_mode = !full_v;
         end
      end
      cyc = 0; done = 1'b0; prev_v = 0; prev_r = 0; prev_acc = 0; prev_d = 0;
      gap_bad = 0; hold_bad = 0;
      while (!done) begin
         @(negedge clk);
         cyc++;
         strobe = '1;                       // strobes during readout (R4)
         start  = poke_start && (cyc == 20); // stray start (R11)
         v = out_valid;
         d = int'(out_data);
         if (prev_acc && v) gap_bad++;
         if (prev_v && !prev_r && (!v || d != prev_d)) hold_bad++;
         case (rdy_mode)
            0:       r = 1'b1;
            1:       r = (cyc % 3) != 0;
            default: r = (cyc % 16) >= 10;
         endcase
         out_ready = r;
         prev_acc = v && r; prev_v = v; prev_r = r; prev_d = d;
         if (v && r) begin
            got.push_back(d);
            if ((got.size() % 2) == 1 && d == TRL) done = 1'b1;
         end
         if (cyc > 8000) done = 1'b1;
      end
      @(negedge clk);
      strobe = '0; start = 1'b0; out_ready = 1'b1;
      chk(got.size() == exp_q.size(), {req, " frame length"}, got.size(), exp_q.size());
      mism = -1;
      for (int i = 0; i < got.size() && i < exp_q.size(); i++)
         if (mism < 0 && got[i] != exp_q[i]) mism = i;
      chk(mism < 0, {req, " byte content"}, (mism < 0) ? 0 : got[mism],
          (mism < 0) ? 0 : exp_q[mism]);
      chk(gap_bad == 0, "R9 idle cycle after each accepted byte", gap_bad, 0);
      chk(hold_bad == 0, "R10 stalled byte held", hold_bad, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; start = 1'b0; strobe = '0; thr = 8'd0; full_mode = 1'b0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R12 valid low in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R12 idle after reset", int'(out_valid), 0);
   endtask

   // R1 R2 R3 R4 R5 R7: sparse frame, exact codes, first strobe wins, saturation
   task automatic t_sparse();
      clear_targets(5);
      tgt[0] = 40;                 // equals threshold
      tgt[1] = 39;                 // just below
      tgt[5] = 60; tgt2[5] = 200;  // second strobe ignored (R2)
      tgt[64] = 255;               // last count of the window (R1)
      tgt[100] = -1;               // never fires, saturates (R3)
      tgt[126] = 250;
      tgt[127] = 0;
      run_frame(40, 1'b0, 0, 1'b0, 1'b0, "R1 R2 R3 R4 R5 sparse");
   endtask

   // R6 R10 R11: full readout under back-pressure with a stray start
   task automatic t_full();
      clear_targets(0);
      for (int ch = 0; ch < NCH; ch++) tgt[ch] = (ch * 2) % 256;
      tgt[127] = 255;
      tgt[3] = -1;
      run_frame(200, 1'b1, 2, 1'b0, 1'b1, "R6 full mode");
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (out_valid) begin
            chk(1'b0, "R11 no frame after ignored start", 1, 0);
            break;
         end
      end
      chk(out_valid == 1'b0, "R11 block stays quiet", int'(out_valid), 0);
   endtask

   // R5 R8: threshold inclusivity, settings changed after start
   task automatic t_thresh_late();
      clear_targets(0);
      tgt[10] = 99; tgt[11] = 100; tgt[12] = 101;
      run_frame(100, 1'b0, 1, 1'b1, 1'b0, "R5 R8 threshold edge and capture");
   endtask

   // R7: empty sparse frame is the trailer alone
   task automatic t_empty();
      clear_targets(0);
      for (int ch = 0; ch < NCH; ch++) tgt[ch] = ch % 50;
      run_frame(60, 1'b0, 0, 1'b0, 1'b0, "R7 empty frame");
   endtask

   initial begin
      t_reset();
      t_sparse();
      t_full();
      t_thresh_late();
      t_empty();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule